// File: doc/BRIEF.md
# Banked Scratchpad Conflict Resolver

This block takes one read request from sixteen lanes to an on-chip scratchpad that is split into sixteen word-interleaved banks. Each lane supplies a word address and an active bit. A bank can deliver only one word per cycle, so lanes that reach the same bank with different word addresses must be served in separate cycles. Lanes that name the very same word share a single access. The block runs one round per cycle. In each round every bank reads at most one word, and the result is sent back to every lane that asked for that word. Rounds continue until no active lane is left, and then the block reports completion together with the number of rounds it used.

A client presents a request while the block is ready and then waits for the completion pulse. Per-lane data arrives on the lane data bus, each word marked by its own valid bit, in the cycle after the bank read that produced it. The bank read ports reach the scratchpad banks, and each bank returns its word in the same cycle. The round count reflects how badly the access pattern conflicts, so software tuning and performance counters can make use of it.

Top module: `scr_conflict_resolver`

## Requirements
- R1: After reset, req_ready is 1 and done, rsp_valid and degree are 0. A request is taken at a clock edge where both req_valid and req_ready are 1. req_ready stays 0 from the cycle after acceptance until the cycle after the last round.
- R2: The bank of a lane is its word address modulo 16 (address bits [3:0]). Its row is the address shifted right by 4, and this row is driven on that bank's slot of bank_rd_addr. A bank is enabled only while a request is in progress, and it carries exactly one row in any cycle.
- R3: In each round, every bank picks the lowest-numbered active lane that it has not yet served. That lane's word is read, and every other unserved lane with the same word address is served in the same round.
- R4: Each lane served in a round has its rsp_valid bit set in the cycle after that round's bank read, and its rsp_data slot holds the word read. Every active lane is served exactly once per request.
- R5: The number of rounds equals the largest count of distinct word addresses that any single bank receives from active lanes. done pulses for one cycle together with the final rsp_valid, and degree then shows the round count and holds it until the next done.
- R6: A request in which all active lanes name the same word finishes in one round with degree 1.
- R7: A stride access (lane l at base + s*l) with odd s finishes in one round. A stride of 2 takes 2 rounds, a stride of 8 takes 8 rounds, and a stride of 16 takes 16 rounds.
- R8: Inactive lanes cause no bank access, get no rsp_valid, and do not change the round count. A request with no active lane finishes one cycle after acceptance with degree 0 and no bank access.
- R9: req_valid, req_addr and req_mask are ignored while a request is in progress. They do not change the rounds, data or degree of the running request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | LANES*AW | Word address per lane, lane l in bits [l*AW +: AW] |
| req_mask | input | LANES | Active bit per lane |
| bank_rd_en | output | BANKS | Read enable per bank |
| bank_rd_addr | output | BANKS*(AW-log2 BANKS) | Row per bank |
| bank_rd_data | input | BANKS*DW | Same-cycle read word per bank |
| rsp_valid | output | LANES | Lane data valid this cycle |
| rsp_data | output | LANES*DW | Data per lane |
| done | output | 1 | One-cycle completion pulse |
| degree | output | $clog2(LANES+1) | Rounds used by the last request |

## Verification
The bench builds the block with its defaults: 16 lanes, 16 banks, 12-bit word addresses and 32-bit data. With these values the full range of conflict degrees can be reached, from broadcast and single-round odd strides up to the 16-round worst case in which every lane names a different row of one bank. Random requests confined to 64 words force repeated addresses inside a bank, so same-word merging and distinct-word serialization happen together in one request. Partial and empty masks cover the handling of inactive lanes.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic {
        RS_IDLE  = 1'b0,
        RS_SERVE = 1'b1
    } rs_state_e;

endpackage

// File: rtl/scr_bank_pick.sv
module scr_bank_pick #(
    parameter int LANES   = 16,
    parameter int AW      = 12,
    parameter int BANKS   = 16,
    parameter int BANK_ID = 0,
    localparam int BW     = $clog2(BANKS)
) (
    input  logic [LANES-1:0]    pend,
    input  logic [LANES*AW-1:0] addr_flat,
    output logic                hit,
    output logic [AW-1:0]       lead_addr
);

    always_comb begin
        hit       = 1'b0;
        lead_addr = '0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (pend[l] && (addr_flat[l*AW +: BW] == BW'(BANK_ID))) begin
                hit       = 1'b1;
                lead_addr = addr_flat[l*AW +: AW];
            end
        end
    end

endmodule

// File: rtl/scr_round_match.sv
module scr_round_match #(
    parameter int LANES = 16,
    parameter int AW    = 12,
    parameter int BANKS = 16,
    localparam int BW   = $clog2(BANKS)
) (
    input  logic [LANES-1:0]    pend,
    input  logic [LANES*AW-1:0] addr_flat,
    input  logic [BANKS*AW-1:0] lead_flat,
    output logic [LANES-1:0]    served
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BW-1:0] bk;
        assign bk        = addr_flat[l*AW +: BW];
        assign served[l] = pend[l] && (addr_flat[l*AW +: AW] == lead_flat[bk*AW +: AW]);
    end

endmodule

// File: rtl/scr_conflict_resolver.sv
module scr_conflict_resolver
    import scr_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int BANKS  = 16,
    parameter int AW     = 12,
    parameter int DW     = 32,
    localparam int BW    = $clog2(BANKS),
    localparam int RW    = AW - BW,
    localparam int DEGW  = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [LANES*AW-1:0]   req_addr,
    input  logic [LANES-1:0]      req_mask,
    output logic [BANKS-1:0]      bank_rd_en,
    output logic [BANKS*RW-1:0]   bank_rd_addr,
    input  logic [BANKS*DW-1:0]   bank_rd_data,
    output logic [LANES-1:0]      rsp_valid,
    output logic [LANES*DW-1:0]   rsp_data,
    output logic                  done,
    output logic [DEGW-1:0]       degree
);

    rs_state_e              state_q;
    logic [LANES-1:0]       pend_q;
    logic [LANES*AW-1:0]    addr_q;
    logic [DEGW-1:0]        rounds_q;
    logic [LANES-1:0]       served;
    logic [LANES-1:0]       remain;
    logic [BANKS-1:0]       lead_hit;
    logic [BANKS*AW-1:0]    lead_flat;
    logic [LANES-1:0]       rsp_valid_q;
    logic [LANES*DW-1:0]    rsp_data_q;
    logic                   done_q;
    logic [DEGW-1:0]        degree_q;
    logic                   serving;

    assign serving = (state_q == RS_SERVE);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        scr_bank_pick #(
            .LANES(LANES), .AW(AW), .BANKS(BANKS), .BANK_ID(b)
        ) u_pick (
            .pend      (pend_q),
            .addr_flat (addr_q),
            .hit       (lead_hit[b]),
            .lead_addr (lead_flat[b*AW +: AW])
        );
        assign bank_rd_en[b]           = serving && lead_hit[b];
        assign bank_rd_addr[b*RW +: RW] = lead_flat[b*AW + BW +: RW];
    end

    scr_round_match #(
        .LANES(LANES), .AW(AW), .BANKS(BANKS)
    ) u_match (
        .pend      (pend_q),
        .addr_flat (addr_q),
        .lead_flat (lead_flat),
        .served    (served)
    );

    assign remain = pend_q & ~served;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= RS_IDLE;
            pend_q      <= '0;
            addr_q      <= '0;
            rounds_q    <= '0;
            rsp_valid_q <= '0;
            rsp_data_q  <= '0;
            done_q      <= 1'b0;
            degree_q    <= '0;
        end else begin
            rsp_valid_q <= '0;
            done_q      <= 1'b0;
            if (!serving) begin
                if (req_valid) begin
                    state_q  <= RS_SERVE;
                    pend_q   <= req_mask;
                    addr_q   <= req_addr;
                    rounds_q <= '0;
                end
            end else begin
                rsp_valid_q <= served;
                for (int l = 0; l < LANES; l++) begin
                    if (served[l]) begin
                        rsp_data_q[l*DW +: DW] <= bank_rd_data[addr_q[l*AW +: BW]*DW +: DW];
                    end
                end
                pend_q   <= remain;
                rounds_q <= rounds_q + DEGW'(|served);
                if (remain == '0) begin
                    state_q  <= RS_IDLE;
                    done_q   <= 1'b1;
                    degree_q <= rounds_q + DEGW'(|served);
                end
            end
        end
    end

    assign req_ready = !serving;
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign done      = done_q;
    assign degree    = degree_q;

endmodule

// File: rtl/scr_resolver_chk.sv
module scr_resolver_chk #(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int DEGW  = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LANES-1:0] req_mask,
    input logic [BANKS-1:0] bank_rd_en,
    input logic [LANES-1:0] rsp_valid,
    input logic             done,
    input logic [DEGW-1:0]  degree
);

    logic [LANES-1:0] mask_lat;
    logic [LANES-1:0] got_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_lat <= '0;
            got_acc  <= '0;
        end else if (req_valid && req_ready) begin
            mask_lat <= req_mask;
            got_acc  <= '0;
        end else begin
            got_acc  <= got_acc | rsp_valid;
        end
    end

    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_bank_idle_when_ready_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (bank_rd_en == '0));

    p_rsp_follows_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid != '0) |-> !$past(req_ready));

    p_single_serve_r4: assert property (@(posedge clk) disable iff (rst)
        ((rsp_valid & got_acc) == '0));

    p_all_served_at_done_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> ((got_acc | rsp_valid) == mask_lat));

    p_done_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_degree_bound_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (32'(degree) <= LANES));

    p_inactive_silent_r8: assert property (@(posedge clk) disable iff (rst)
        ((rsp_valid & ~mask_lat) == '0));

endmodule

bind scr_conflict_resolver scr_resolver_chk #(
    .LANES(LANES), .BANKS(BANKS), .DEGW(DEGW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_mask   (req_mask),
    .bank_rd_en (bank_rd_en),
    .rsp_valid  (rsp_valid),
    .done       (done),
    .degree     (degree)
);

// File: tb/test_scr_conflict_resolver.sv
module test_scr_conflict_resolver;

    localparam int NL = 16;
    localparam int NB = 16;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int RW = AW - 4;
    localparam int DEGW = $clog2(NL + 1);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [NL*AW-1:0]    req_addr = '0;
    logic [NL-1:0]       req_mask = '0;
    logic [NB-1:0]       bank_rd_en;
    logic [NB*RW-1:0]    bank_rd_addr;
    logic [NB*DW-1:0]    bank_rd_data;
    logic [NL-1:0]       rsp_valid;
    logic [NL*DW-1:0]    rsp_data;
    logic                done;
    logic [DEGW-1:0]     degree;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] word_val(int wa);
        return 32'h1357_0000 + 32'(wa) * 32'h0001_0003;
    endfunction

    for (genvar b = 0; b < NB; b++) begin : g_mem
        assign bank_rd_data[b*DW +: DW] = word_val(int'(bank_rd_addr[b*RW +: RW]) * NB + b);
    end

    scr_conflict_resolver i_scr_conflict_resolver (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .bank_rd_en(bank_rd_en),
        .bank_rd_addr(bank_rd_addr), .bank_rd_data(bank_rd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .degree(degree)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference, evaluated just after every rising edge
    bit m_busy = 0;
    bit m_pend [NL];
    int m_addr [NL];
    int m_rounds = 0;
    int m_deg = 0;

    function automatic void leaders(output int lead [NB]);
        for (int b = 0; b < NB; b++) lead[b] = -1;
        for (int l = 0; l < NL; l++)
            if (m_pend[l] && lead[m_addr[l] % NB] < 0) lead[m_addr[l] % NB] = l;
    endfunction

    always @(posedge clk) begin
        #1;
        if (rst) begin
            m_busy = 0; m_rounds = 0; m_deg = 0;
            for (int l = 0; l < NL; l++) m_pend[l] = 0;
        end else begin
            bit [NL-1:0] exp_rv;
            bit exp_done;
            int lead [NB];
            exp_rv = '0;
            exp_done = 0;
            if (m_busy) begin
                bit left;
                leaders(lead);
                for (int l = 0; l < NL; l++)
                    if (m_pend[l] && lead[m_addr[l] % NB] >= 0 &&
                        m_addr[lead[m_addr[l] % NB]] == m_addr[l]) exp_rv[l] = 1;
                for (int l = 0; l < NL; l++) begin
                    if (exp_rv[l]) begin
                        m_pend[l] = 0;
                        chk(rsp_data[l*DW +: DW] == word_val(m_addr[l]), "R4 lane data",
                            rsp_data[l*DW +: DW], word_val(m_addr[l]));
                    end
                end
                if (exp_rv != 0) m_rounds++;
                left = 0;
                for (int l = 0; l < NL; l++) left |= m_pend[l];
                if (!left) begin
                    m_busy = 0; exp_done = 1; m_deg = m_rounds;
                end
            end else if (req_valid) begin
                m_busy = 1; m_rounds = 0;
                for (int l = 0; l < NL; l++) begin
                    m_pend[l] = req_mask[l];
                    m_addr[l] = int'(req_addr[l*AW +: AW]);
                end
            end
            chk(rsp_valid == exp_rv, "R3 served lanes", rsp_valid, exp_rv);
            chk(done == exp_done, "R5 done pulse", done, exp_done);
            chk(req_ready == !m_busy, "R1 ready", req_ready, !m_busy);
            chk(int'(degree) == m_deg, "R5 degree", degree, m_deg);
            leaders(lead);
            for (int b = 0; b < NB; b++) begin
                bit en;
                en = m_busy && lead[b] >= 0;
                chk(bank_rd_en[b] == en, "R2 bank enable", bank_rd_en[b], en);
                if (en)
                    chk(int'(bank_rd_addr[b*RW +: RW]) == m_addr[lead[b]] / NB, "R2 bank row",
                        bank_rd_addr[b*RW +: RW], m_addr[lead[b]] / NB);
            end
        end
    end

    function automatic int ref_degree(input int a [NL], input bit [NL-1:0] m);
        int worst = 0;
        for (int b = 0; b < NB; b++) begin
            int cnt = 0;
            for (int l = 0; l < NL; l++) begin
                if (m[l] && a[l] % NB == b) begin
                    bit seen = 0;
                    for (int k = 0; k < l; k++)
                        if (m[k] && a[k] == a[l]) seen = 1;
                    if (!seen) cnt++;
                end
            end
            if (cnt > worst) worst = cnt;
        end
        return worst;
    endfunction

    task automatic send(input int a [NL], input bit [NL-1:0] m, input int exp_deg,
                        input string tag, input bit poke);
        int cyc = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1;
        req_mask = m;
        for (int l = 0; l < NL; l++) req_addr[l*AW +: AW] = AW'(a[l]);
        @(negedge clk);
        req_valid = 0;
        req_mask = '0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 1) begin
                req_valid = 1; req_mask = '1; req_addr = '0;
            end else if (poke && cyc == 2) begin
                req_valid = 0; req_mask = '0;
            end
        end
        chk(int'(degree) == exp_deg, {tag, " degree"}, degree, exp_deg);
        chk(cyc == ((exp_deg == 0) ? 1 : exp_deg), {tag, " cycles"}, cyc,
            (exp_deg == 0) ? 1 : exp_deg);
    endtask

    task automatic stride(input int base, input int s, output int a [NL]);
        for (int l = 0; l < NL; l++) a[l] = (base + s * l) % (1 << AW);
    endtask

    initial begin
        int a [NL];
        repeat (3) @(negedge clk);
        rst = 0;
        chk(req_ready == 1, "R1 reset ready", req_ready, 1);
        chk(done == 0, "R1 reset done", done, 0);
        chk(rsp_valid == 0, "R1 reset rsp_valid", rsp_valid, 0);
        chk(degree == 0, "R1 reset degree", degree, 0);

        for (int l = 0; l < NL; l++) a[l] = 100;
        send(a, '1, 1, "R6 broadcast", 0);
        stride(0, 1, a);   send(a, '1, 1, "R7 stride 1", 0);
        stride(7, 3, a);   send(a, '1, 1, "R7 stride 3", 0);
        stride(21, 5, a);  send(a, '1, 1, "R7 stride 5", 0);
        stride(0, 2, a);   send(a, '1, 2, "R7 stride 2", 0);
        stride(3, 8, a);   send(a, '1, 8, "R7 stride 8", 0);
        stride(0, 16, a);  send(a, '1, 16, "R7 stride 16", 0);
        stride(0, 16, a);  send(a, '1, 16, "R9 busy ignore", 1);
        for (int l = 0; l < NL; l++) a[l] = (l < 8) ? 32 : 48;
        send(a, '1, 2, "R3 merge per word", 0);
        stride(0, 16, a);  send(a, 16'h0003, 2, "R8 partial mask", 0);
        send(a, 16'h8001, 2, "R8 end lanes", 0);
        send(a, '0, 0, "R8 empty mask", 0);

        for (int t = 0; t < 60; t++) begin
            bit [NL-1:0] m;
            for (int l = 0; l < NL; l++) a[l] = int'($urandom % 64);
            m = NL'($urandom);
            if (t % 5 == 0) m = '1;
            send(a, m, ref_degree(a, m), "R5 random", 0);
        end

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R5 watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule